// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Controller

This block is a small 8-bit accumulator processor with a multi-cycle sequencer. It reads every instruction from a byte-wide memory with a 16-bit address, three bytes at a time. The first byte carries the operation. The next two bytes form a 16-bit address. A three-step phase counter steers each fetched byte into exactly one of three holding registers: the operation register, the upper address register or the lower address register. An operand byte therefore can never land in the operation register.

Load, arithmetic and store instructions get a separate execute step. That step drives the assembled address onto the memory port, while the program counter stays on the instruction stream. The arithmetic unit has one adder and one subtract select. A carry flag and a zero flag feed the conditional jumps. Halt freezes the machine. A reset operation restarts it from address zero. The memory is synchronous: read data appears one clock after its address.

The external reset is asynchronous and active low, and two flops release it synchronously. The first state change therefore happens on the third rising edge after `rst_n` rises.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low, `mem_addr` is 0, `mem_we` is 0, `halted` is 0 and `acc_out` is 0. After release, the first instruction is fetched from address 0.
- R2: An instruction is three bytes at pc, pc+1 and pc+2. The opcode is bits [3:0] of the first byte, and bits [7:4] are ignored. The second byte is address bits [15:8] and the third is bits [7:0].
- R3: Opcode 0x1 (load) copies the byte at the address into the accumulator and leaves both flags unchanged.
- R4: Opcode 0x2 computes acc+M and opcode 0x3 computes acc+M+C. Carry out goes to C, and Z is set when the 8-bit result is zero.
- R5: Opcode 0x4 computes acc+~M+1 and opcode 0x5 computes acc+~M+C, so C=1 means no borrow. C and Z update as in R4.
- R6: Opcode 0xB (store) writes the accumulator to the address in a single write cycle. The accumulator and the flags are left unchanged.
- R7: Opcode 0x6 always jumps. Opcodes 0x7, 0x8, 0x9 and 0xA jump when C=1, Z=1, C=0 and Z=0 respectively. A taken jump loads pc with the address; otherwise pc becomes pc+3.
- R8: A data access (opcodes 0x1–0x5, 0xB) never moves the instruction stream. The next fetch is at pc+3.
- R9: Opcode 0xC asserts `halted`. From then until reset, no write occurs and `mem_addr` and `acc_out` stay constant.
- R10: Opcode 0xD clears pc, the accumulator, C and Z. The very next cycle drives address 0.
- R11: Opcodes 0x0, 0xE and 0xF change neither the accumulator, the flags nor memory, and continue at pc+3.
- R12: Load and arithmetic take 6 clocks. Store, jumps, reset and undefined opcodes take 5 clocks. Halt is asserted 5 clocks after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one clock after its address |
| mem_we | output | 1 | Memory write enable |
| halted | output | 1 | High while stopped by the halt operation |
| acc_out | output | 8 | Current accumulator value |

## Verification
Each result falls due on a cycle the bench can count:
- A fetch needs one address-issue clock, then three latch clocks, then one execute clock.
- Load and arithmetic add one more clock in which the read data arrives.
- After reset release, two synchronizer clocks pass before any of this starts.

The bench counts rising edges from reset release and samples on the falling edge after each one. It compares the edge on which `halted` first appears against the sum of the instruction cycle counts and the two-clock release. For the reset operation, it probes the accumulator and address on the exact edges before and after the operation takes effect. Arithmetic results and flags are swept over operand pairs, carry-in values and all four arithmetic opcodes. Each result and flag is exposed through stores and conditional jumps once the program has halted.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W        = 4;
  localparam int FETCH_PHASES = 3;

  typedef logic [OPC_W-1:0] opc_t;

  localparam opc_t OPC_LOAD  = 4'h1;
  localparam opc_t OPC_ADD   = 4'h2;
  localparam opc_t OPC_ADC   = 4'h3;
  localparam opc_t OPC_SUB   = 4'h4;
  localparam opc_t OPC_SBB   = 4'h5;
  localparam opc_t OPC_JMP   = 4'h6;
  localparam opc_t OPC_JC    = 4'h7;
  localparam opc_t OPC_JZ    = 4'h8;
  localparam opc_t OPC_JNC   = 4'h9;
  localparam opc_t OPC_JNZ   = 4'hA;
  localparam opc_t OPC_STORE = 4'hB;
  localparam opc_t OPC_HALT  = 4'hC;
  localparam opc_t OPC_RST   = 4'hD;

  typedef enum logic [2:0] {
    ST_ISSUE,
    ST_FETCH,
    ST_EXEC,
    ST_DATA,
    ST_HALT
  } seq_state_e;

endpackage

// File: rtl/acc_cpu_fetch.sv
module acc_cpu_fetch
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PHASES = FETCH_PHASES
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fetch_en,
  input  logic [DATA_W-1:0]            rdata,
  output logic [$clog2(PHASES)-1:0]    phase,
  output logic                         last,
  output opc_t                         opc,
  output logic [(PHASES-1)*DATA_W-1:0] addr
);

  localparam int PH_W = $clog2(PHASES);

  logic [PH_W-1:0] phase_q, phase_d;

  assign phase = phase_q;
  assign last  = (phase_q == PH_W'(PHASES - 1));

  always_comb begin
    phase_d = phase_q;
    if (fetch_en) begin
      phase_d = last ? '0 : phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // One holding register per phase; only the phase-selected one loads.
  for (genvar g = 0; g < PHASES; g++) begin : g_latch
    logic load_en;
    assign load_en = fetch_en && (phase_q == PH_W'(g));
    if (g == 0) begin : g_code
      opc_t opc_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       opc_q <= '0;
        else if (load_en) opc_q <= rdata[OPC_W-1:0];
      end
      assign opc = opc_q;
    end else begin : g_addr
      logic [DATA_W-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       byte_q <= '0;
        else if (load_en) byte_q <= rdata;
      end
      assign addr[(PHASES-1-g)*DATA_W +: DATA_W] = byte_q;
    end
  end

  // R2: a fetch lasts exactly the three phases, then hands over to execute
  assert_three_phases_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en && last |=> !fetch_en)
    else $error("fetch ran past its last phase");

  // R2: every fetch starts at the opcode phase
  assert_phase_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_en) |-> phase_q == '0)
    else $error("fetch started mid-sequence");

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] m,
  input  logic              sub,
  input  logic              use_c,
  input  logic              c_in,
  output logic [DATA_W-1:0] res,
  output logic              c_out
);

  logic [DATA_W-1:0] opnd;
  logic              cin;
  logic [DATA_W:0]   sum;

  always_comb begin
    opnd = sub ? ~m : m;
    cin  = use_c ? c_in : sub;
    sum  = {1'b0, a} + {1'b0, opnd} + {{DATA_W{1'b0}}, cin};
  end

  assign res   = sum[DATA_W-1:0];
  assign c_out = sum[DATA_W];

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int PH_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_last,
  input  logic [PH_W-1:0]   phase,
  input  opc_t              opc,
  input  logic [ADDR_W-1:0] tgt,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_c,
  output logic              fetch_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              halted,
  output logic [DATA_W-1:0] acc,
  output logic              carry,
  output logic              alu_sub,
  output logic              alu_usec
);

  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(3);

  seq_state_e        st_q, st_d;
  logic [ADDR_W-1:0] pc_q, pc_d, pc_next;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              c_q, c_d, z_q, z_d;
  logic              take;

  assign pc_next   = pc_q + INSN_BYTES;
  assign mem_wdata = acc_q;
  assign halted    = (st_q == ST_HALT);
  assign acc       = acc_q;
  assign carry     = c_q;

  always_comb begin
    unique case (opc)
      OPC_JMP: take = 1'b1;
      OPC_JC:  take = c_q;
      OPC_JZ:  take = z_q;
      OPC_JNC: take = !c_q;
      OPC_JNZ: take = !z_q;
      default: take = 1'b0;
    endcase
  end

  always_comb begin
    st_d     = st_q;
    pc_d     = pc_q;
    acc_d    = acc_q;
    c_d      = c_q;
    z_d      = z_q;
    mem_addr = pc_q;
    mem_we   = 1'b0;
    fetch_en = 1'b0;
    alu_sub  = (opc == OPC_SUB) || (opc == OPC_SBB);
    alu_usec = (opc == OPC_ADC) || (opc == OPC_SBB);
    unique case (st_q)
      ST_ISSUE: st_d = ST_FETCH;
      ST_FETCH: begin
        fetch_en = 1'b1;
        mem_addr = pc_q + ADDR_W'(phase) + ADDR_W'(1);
        if (fetch_last) st_d = ST_EXEC;
      end
      ST_EXEC: begin
        st_d = ST_ISSUE;
        unique case (opc)
          OPC_LOAD, OPC_ADD, OPC_ADC, OPC_SUB, OPC_SBB: begin
            mem_addr = tgt;
            st_d     = ST_DATA;
          end
          OPC_STORE: begin
            mem_addr = tgt;
            mem_we   = 1'b1;
            pc_d     = pc_next;
          end
          OPC_JMP, OPC_JC, OPC_JZ, OPC_JNC, OPC_JNZ:
            pc_d = take ? tgt : pc_next;
          OPC_HALT: st_d = ST_HALT;
          OPC_RST: begin
            pc_d  = '0;
            acc_d = '0;
            c_d   = 1'b0;
            z_d   = 1'b0;
          end
          default: pc_d = pc_next;
        endcase
      end
      ST_DATA: begin
        mem_addr = tgt;
        pc_d     = pc_next;
        st_d     = ST_ISSUE;
        if (opc == OPC_LOAD) begin
          acc_d = mem_rdata;
        end else begin
          acc_d = alu_res;
          c_d   = alu_c;
          z_d   = (alu_res == '0);
        end
      end
      ST_HALT: st_d = ST_HALT;
      default: st_d = ST_ISSUE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_ISSUE;
      pc_q  <= '0;
      acc_q <= '0;
      c_q   <= 1'b0;
      z_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      pc_q  <= pc_d;
      acc_q <= acc_d;
      c_q   <= c_d;
      z_q   <= z_d;
    end
  end

  // R6: a write goes to the assembled address and carries the accumulator
  assert_store_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == tgt) && (mem_wdata == acc_q))
    else $error("store to wrong address or data");

  // R8: the data step resumes the stream three bytes on
  assert_stream_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_DATA |=> pc_q == $past(pc_q) + INSN_BYTES)
    else $error("data access moved the program counter");

  // R7: unconditional jump lands on the fetched address
  assert_jump_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXEC) && (opc == OPC_JMP) |=> pc_q == $past(tgt))
    else $error("jump did not reach its target");

  // R9: once halted, nothing moves
  assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !mem_we && $stable(mem_addr) && $stable(acc_q))
    else $error("activity while halted");

  // R10: reset operation clears the architectural state
  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXEC) && (opc == OPC_RST) |=> (pc_q == '0) && (acc_q == '0) && !c_q && !z_q)
    else $error("reset operation left state behind");

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                mem_we,
  output logic                halted,
  output logic [DATA_W-1:0]   acc_out
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam int PH_W   = $clog2(FETCH_PHASES);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              fetch_en, fetch_last;
  logic [PH_W-1:0]   phase;
  opc_t              opc;
  logic [ADDR_W-1:0] tgt;
  logic [DATA_W-1:0] acc, alu_res;
  logic              carry, alu_c, alu_sub, alu_usec;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  acc_cpu_fetch #(.DATA_W(DATA_W), .PHASES(FETCH_PHASES)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fetch_en (fetch_en),
    .rdata    (mem_rdata),
    .phase    (phase),
    .last     (fetch_last),
    .opc      (opc),
    .addr     (tgt)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .a     (acc),
    .m     (mem_rdata),
    .sub   (alu_sub),
    .use_c (alu_usec),
    .c_in  (carry),
    .res   (alu_res),
    .c_out (alu_c)
  );

  acc_cpu_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PH_W(PH_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .fetch_last (fetch_last),
    .phase      (phase),
    .opc        (opc),
    .tgt        (tgt),
    .mem_rdata  (mem_rdata),
    .alu_res    (alu_res),
    .alu_c      (alu_c),
    .fetch_en   (fetch_en),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .halted     (halted),
    .acc        (acc),
    .carry      (carry),
    .alu_sub    (alu_sub),
    .alu_usec   (alu_usec)
  );

  assign acc_out = acc;

endmodule

// File: tb/test_acc_cpu.sv
`timescale 1ns/1ps
module test_acc_cpu;

  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we, halted;
  logic [7:0]  acc_out;

  logic        tb_we = 1'b0;
  logic [15:0] tb_a = '0;
  logic [7:0]  tb_d = '0;
  logic [7:0]  mem [512];

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  acc_cpu i_acc_cpu (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .halted    (halted),
    .acc_out   (acc_out)
  );

  function automatic int ix(input logic [15:0] a);
    return int'({a[12], a[7:0]});
  endfunction

  always @(posedge clk) begin
    if (tb_we)       mem[ix(tb_a)]    <= tb_d;
    else if (mem_we) mem[ix(mem_addr)] <= mem_wdata;
    mem_rdata <= mem[ix(mem_addr)];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    tb_a = a; tb_d = d; tb_we = 1'b1;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic ins(input logic [15:0] at, input logic [7:0] code, input logic [15:0] t);
    poke(at, code);
    poke(at + 16'd1, t[15:8]);
    poke(at + 16'd2, t[7:0]);
  endtask

  task automatic run_prog(output int edges);
    bit done = 0;
    edges = 0;
    rst_n = 1'b1;
    while (!done) begin
      @(negedge clk);
      edges++;
      if (halted) done = 1;
      else if (edges > 3000) begin
        chk(1'b0, "watchdog", edges, 0);
        done = 1;
      end
    end
  endtask

  function automatic logic [7:0] val(input int k);
    case (k)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h7F; 3: return 8'h80;
      4: return 8'hFE; 5: return 8'hFF; 6: return 8'h55; default: return 8'hAA;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int e;
    @(negedge clk);
    // R1: outputs while reset is held
    chk(mem_addr == 16'h0 && !mem_we && !halted && acc_out == 8'h0, "R1", mem_addr, 0);
    for (int i = 0; i < 512; i++) poke(i[8] ? 16'h1000 | 16'(i[7:0]) : 16'(i[7:0]), 8'h00);
    chk(mem_addr == 16'h0 && !halted, "R1", mem_addr, 0);

    // R2/R3/R12: load with upper nibble set, then halt
    ins(16'd0, 8'hF1, 16'h1050);
    ins(16'd3, 8'h0C, 16'h0000);
    poke(16'h1050, 8'h3C);
    run_prog(e);
    chk(acc_out == 8'h3C, "R2 R3", acc_out, 8'h3C);
    chk(e == SYNC + 11, "R12", e, SYNC + 11);
    begin
      logic [7:0]  a0;
      logic [15:0] ad;
      a0 = acc_out; ad = mem_addr;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        chk(halted && !mem_we && acc_out == a0 && mem_addr == ad, "R9", acc_out, a0);
      end
    end

    // R7/R6: jump-if-no-carry not taken then taken, store
    rst_n = 1'b0;
    ins(16'd0,  8'h01, 16'h1025);
    ins(16'd3,  8'h02, 16'h1026);
    ins(16'd6,  8'h09, 16'd15);
    ins(16'd9,  8'h02, 16'h1024);
    ins(16'd12, 8'h09, 16'd18);
    ins(16'd15, 8'h0C, 16'h0000);
    ins(16'd18, 8'h0B, 16'h1030);
    ins(16'd21, 8'h0C, 16'h0000);
    poke(16'h1024, 8'h00); poke(16'h1025, 8'hFF); poke(16'h1026, 8'h02); poke(16'h1030, 8'h00);
    run_prog(e);
    chk(mem[ix(16'h1030)] == 8'h01, "R6 R7", mem[ix(16'h1030)], 1);
    chk(acc_out == 8'h01, "R6", acc_out, 1);
    chk(e == SYNC + 38, "R7 R12", e, SYNC + 38);

    // R11: undefined opcodes keep acc, flags and memory
    rst_n = 1'b0;
    ins(16'd0,  8'h01, 16'h1040);
    ins(16'd3,  8'h02, 16'h1040);
    ins(16'd6,  8'h01, 16'h1041);
    ins(16'd9,  8'h00, 16'h1042);
    ins(16'd12, 8'h0E, 16'h1042);
    ins(16'd15, 8'h0F, 16'h1042);
    ins(16'd18, 8'h07, 16'd24);
    ins(16'd21, 8'h0C, 16'h0000);
    ins(16'd24, 8'h08, 16'd30);
    ins(16'd27, 8'h0C, 16'h0000);
    ins(16'd30, 8'h0B, 16'h1043);
    ins(16'd33, 8'h0C, 16'h0000);
    poke(16'h1040, 8'h80); poke(16'h1041, 8'h5A); poke(16'h1042, 8'h33); poke(16'h1043, 8'h00);
    run_prog(e);
    chk(mem[ix(16'h1043)] == 8'h5A, "R11", mem[ix(16'h1043)], 8'h5A);
    chk(mem[ix(16'h1042)] == 8'h33, "R11", mem[ix(16'h1042)], 8'h33);
    chk(e == SYNC + 53, "R11 R12", e, SYNC + 53);

    // R10: reset operation, probed on its exact edges
    rst_n = 1'b0;
    ins(16'd0,  8'h01, 16'h1020);
    ins(16'd3,  8'h07, 16'd27);
    ins(16'd6,  8'h02, 16'h1024);
    ins(16'd9,  8'h0A, 16'd24);
    ins(16'd12, 8'h01, 16'h1025);
    ins(16'd15, 8'h02, 16'h1026);
    ins(16'd18, 8'h0B, 16'h1020);
    ins(16'd21, 8'h0D, 16'h0000);
    ins(16'd24, 8'h0C, 16'h0000);
    ins(16'd27, 8'h01, 16'h1025);
    ins(16'd30, 8'h0B, 16'h1027);
    ins(16'd33, 8'h0C, 16'h0000);
    poke(16'h1020, 8'h00); poke(16'h1027, 8'h00);
    begin
      bit done = 0;
      e = 0;
      rst_n = 1'b1;
      while (!done) begin
        @(negedge clk);
        e++;
        if (e == SYNC + 43) chk(acc_out == 8'h01, "R10", acc_out, 1);
        if (e == SYNC + 44) chk(acc_out == 8'h00 && mem_addr == 16'h0, "R10", mem_addr, 0);
        if (halted || e > 3000) done = 1;
      end
    end
    chk(mem[ix(16'h1027)] == 8'h00, "R10", mem[ix(16'h1027)], 0);
    chk(acc_out == 8'h01 && e == SYNC + 71, "R10 R7", e, SYNC + 71);

    // R4/R5/R8: arithmetic sweep; result, carry and zero exposed by stores
    rst_n = 1'b0;
    ins(16'd0,  8'h01, 16'h1003);
    ins(16'd3,  8'h02, 16'h1004);
    ins(16'd6,  8'h01, 16'h1000);
    ins(16'd9,  8'h02, 16'h1001);
    ins(16'd12, 8'h0B, 16'h1010);
    ins(16'd15, 8'h07, 16'd21);
    ins(16'd18, 8'h06, 16'd27);
    ins(16'd21, 8'h01, 16'h1005);
    ins(16'd24, 8'h0B, 16'h1011);
    ins(16'd27, 8'h08, 16'd33);
    ins(16'd30, 8'h0C, 16'h0000);
    ins(16'd33, 8'h01, 16'h1005);
    ins(16'd36, 8'h0B, 16'h1012);
    ins(16'd39, 8'h0C, 16'h0000);
    poke(16'h1005, 8'h01);
    for (int op = 0; op < 4; op++) begin
      for (int cin = 0; cin < 2; cin++) begin
        for (int ia = 0; ia < 8; ia++) begin
          for (int ib = 0; ib < 8; ib++) begin
            logic [7:0] a, b, r, code;
            logic [8:0] s;
            bit         c, z;
            a = val(ia); b = val(ib);
            code = {4'(ia + ib), 4'(op + 2)};
            case (op)
              0: s = {1'b0, a} + {1'b0, b};
              1: s = {1'b0, a} + {1'b0, b} + 9'(cin);
              2: s = {1'b0, a} + {1'b0, ~b} + 9'd1;
              default: s = {1'b0, a} + {1'b0, ~b} + 9'(cin);
            endcase
            r = s[7:0]; c = s[8]; z = (r == 8'h00);
            rst_n = 1'b0;
            poke(16'h1000, a); poke(16'h1001, b);
            poke(16'h1003, cin ? 8'hFF : 8'h00); poke(16'h1004, cin ? 8'h01 : 8'h00);
            poke(16'd9, code);
            poke(16'h1010, 8'h00); poke(16'h1011, 8'h00); poke(16'h1012, 8'h00);
            run_prog(e);
            chk(mem[ix(16'h1010)] == r, op < 2 ? "R4 result" : "R5 result", mem[ix(16'h1010)], r);
            chk(mem[ix(16'h1011)] == 8'(c), op < 2 ? "R4 carry" : "R5 carry", mem[ix(16'h1011)], c);
            chk(mem[ix(16'h1012)] == 8'(z), op < 2 ? "R4 zero R8" : "R5 zero R8", mem[ix(16'h1012)], z);
          end
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule